// File: doc/BRIEF.md
# Sensor Sample Register Bank

This block keeps the most recent X, Y and Z acceleration samples in a small byte-addressed register map, next to a group of configuration bytes. A sampling engine pushes a fresh result for one axis at a time through a per-axis update strobe, at whatever output data rate it runs. Rates range from a few hertz to several hundred hertz, so an update is a rare, single-cycle event. A host reads and writes the map over a simple strobe-based register bus. Read data appears on the cycle after the read strobe and stays there until the next read.

How each axis byte is presented depends on a two-bit range field, held in the top two bits of configuration byte 0x13. When the field is zero the map is in narrow mode. Each axis byte then shows a signed six-bit sample in bits 5:0, bit 7 is forced to zero, and bit 6 warns the host that this very read met an update of the same axis, so the value must be fetched again. When the field is non-zero the map is in wide mode, and the byte is the full signed eight-bit sample with no warning bit. A sampling engine that produces six-bit results can mark them, and the block then sign-extends them into a full byte when it stores them.

Configuration bytes may only be changed in standby. Once the mode byte at 0x07 has bit 0 set (active), the block drops every host write except a write to that mode byte.

Top module: `accel_sample_regs`

## Requirements
- R1: After reset, every axis byte (addresses 0x00, 0x01, 0x02) and every configuration byte reads 0x00, so the block starts in standby and in narrow mode.
- R2: In narrow mode (bits 7:6 of byte 0x13 equal to 0), an axis read returns bit 7 = 0, bit 6 = collision flag, and bits 5:0 = bits 5:0 of the stored sample.
- R3: In wide mode (bits 7:6 of byte 0x13 non-zero), an axis read returns the stored 8-bit sample unchanged, even when the read meets an update.
- R4: In narrow mode, a read of axis address A in the same cycle as the update strobe for axis A returns bit 6 = 1, together with the sample stored before that update.
- R5: The next read of that axis that meets no update returns bit 6 = 0 and the newly stored sample.
- R6: An update of one axis does not raise the collision flag on a simultaneous read of a different axis.
- R7: When the sample is flagged as six-bit, bits 5:0 of the input are stored with bit 5 copied into bits 7:6, and the input bits 7:6 are ignored.
- R8: Read data appears on the cycle after the read strobe and is held unchanged until the next read strobe, including across sample updates.
- R9: Host writes to the axis addresses 0x00 to 0x02 are ignored.
- R10: While bit 0 of byte 0x07 is 1 (active), host writes to any address other than 0x07 are ignored. A write to 0x07 is always accepted.
- R11: In standby, a write to a configuration address (0x06 to 0x14, except 0x0A and 0x0B) is stored and read back unchanged.
- R12: Addresses 0x03 to 0x05, 0x0A, 0x0B and anything above 0x14 read 0x00, and writes to them are ignored.
- R13: Output cfg_mode follows bit 0 of byte 0x07, and output cfg_range follows bits 7:6 of byte 0x13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 8 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd and held |
| smp_wr | input | 3 | Per-axis update strobe (bit 0 X, bit 1 Y, bit 2 Z) |
| smp_data | input | 8 | Sample value for the strobed axis |
| smp_narrow | input | 1 | Sample is a six-bit value in bits 5:0 |
| cfg_mode | output | 1 | 1 when active, 0 in standby |
| cfg_range | output | 2 | Range field; 0 selects narrow mode |

## Verification
Samples are chosen so that bit 5 and bit 7 differ, and each is read in both modes. This shows whether narrow mode truly masks bit 7 and whether the sign extension takes place at store time rather than at read time. Reads are placed in the same cycle as an update of the same axis, of another axis, and of the same axis in wide mode. Together these separate a real collision from a false flag and show that the flag clears on a clean re-read. Writes are made to configuration addresses, to axis addresses and to reserved addresses, each in standby and again while active, so that loose gating or loose decode shows up in a later read-back.

// File: rtl/accel_regs_pkg.sv
package accel_regs_pkg;

  // Fixed byte map of the bank
  localparam int unsigned MAP_ADDR_W = 8;
  localparam int unsigned MAP_BYTE_W = 8;
  localparam int unsigned MAP_AXES   = 3;
  localparam int unsigned CFG_FIRST  = 'h06;
  localparam int unsigned CFG_LAST   = 'h14;
  localparam int unsigned CFG_HOLE_A = 'h0A;
  localparam int unsigned CFG_HOLE_B = 'h0B;
  localparam int unsigned MODE_ADDR  = 'h07;
  localparam int unsigned RANGE_ADDR = 'h13;
  localparam int unsigned MODE_BIT   = 0;
  localparam int unsigned RANGE_MSB  = 7;
  localparam int unsigned RANGE_LSB  = 6;

  typedef enum logic {
    FMT_NARROW = 1'b0,
    FMT_WIDE   = 1'b1
  } axis_fmt_e;

endpackage

// File: rtl/accel_axis_slot.sv
module accel_axis_slot
  import accel_regs_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NARROW_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              upd_narrow,
  input  logic              rd_hit,
  input  axis_fmt_e         fmt,
  output logic [DATA_W-1:0] view
);

  localparam int unsigned EXT_W = DATA_W - NARROW_W;
  localparam int unsigned PAD_W = DATA_W - NARROW_W - 1;

  logic [DATA_W-1:0] sample_q;
  logic [DATA_W-1:0] sample_d;
  logic [DATA_W-1:0] upd_ext;
  logic              collide;

  // Six-bit input widened with its own sign bit
  always_comb begin
    upd_ext = {{EXT_W{upd_data[NARROW_W-1]}}, upd_data[NARROW_W-1:0]};
    sample_d = upd_narrow ? upd_ext : upd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
    end else if (upd) begin
      sample_q <= sample_d;
    end
  end

  // A read meeting an update sees the previous sample plus the warning bit
  assign collide = upd & rd_hit;

  always_comb begin
    if (fmt == FMT_WIDE) begin
      view = sample_q;
    end else begin
      view = {{PAD_W{1'b0}}, collide, sample_q[NARROW_W-1:0]};
    end
  end

endmodule

// File: rtl/accel_cfg_bank.sv
module accel_cfg_bank
  import accel_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_byte,
  output logic              mode_active,
  output logic [1:0]        range_sel
);

  localparam int unsigned NCFG      = CFG_LAST - CFG_FIRST + 1;
  localparam int unsigned MODE_IDX  = MODE_ADDR - CFG_FIRST;
  localparam int unsigned RANGE_IDX = RANGE_ADDR - CFG_FIRST;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);

  logic [NCFG-1:0][DATA_W-1:0] cfg_q;
  logic [NCFG-1:0][DATA_W-1:0] cfg_d;
  logic [NCFG-1:0]             hit;
  logic                        wr_ok;

  // One decode line per implemented byte; holes never decode
  for (genvar g = 0; g < NCFG; g++) begin : g_dec
    localparam int unsigned A = CFG_FIRST + g;
    if (A == CFG_HOLE_A || A == CFG_HOLE_B) begin : g_hole
      assign hit[g] = 1'b0;
    end else begin : g_live
      assign hit[g] = (addr == ADDR_W'(A));
    end
  end

  assign mode_active = cfg_q[MODE_IDX][MODE_BIT];
  assign range_sel   = cfg_q[RANGE_IDX][RANGE_MSB:RANGE_LSB];

  // Standby gate: only the mode byte stays writable while active
  assign wr_ok = wr && (|hit) && (!mode_active || addr == A_MODE);

  always_comb begin
    cfg_d = cfg_q;
    for (int i = 0; i < NCFG; i++) begin
      if (hit[i]) cfg_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_ok) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NCFG; i++) begin
      if (hit[i]) rd_byte = cfg_q[i];
    end
  end

endmodule

// File: rtl/accel_rd_port.sv
module accel_rd_port #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AXES   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [AXES-1:0][DATA_W-1:0] axis_view,
  input  logic [DATA_W-1:0]          cfg_byte,
  output logic [DATA_W-1:0]          rdata
);

  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rdata_d = cfg_byte;
    for (int i = 0; i < AXES; i++) begin
      if (addr == ADDR_W'(i)) rdata_d = axis_view[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/accel_sample_regs.sv
module accel_sample_regs
  import accel_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = MAP_ADDR_W,
  parameter int unsigned DATA_W   = MAP_BYTE_W,
  parameter int unsigned NARROW_W = 6,
  parameter int unsigned AXES     = MAP_AXES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [AXES-1:0]   smp_wr,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_narrow,
  output logic              cfg_mode,
  output logic [1:0]        cfg_range
);

  logic [1:0]                 rst_sync;
  logic                       rst_n_i;
  logic [AXES-1:0][DATA_W-1:0] axis_view;
  logic [DATA_W-1:0]          cfg_byte;
  axis_fmt_e                  fmt;

  // Reset asserts at once and leaves on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync[1];

  assign fmt = (cfg_range == 2'b00) ? FMT_NARROW : FMT_WIDE;

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    accel_axis_slot #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n_i),
      .upd        (smp_wr[g]),
      .upd_data   (smp_data),
      .upd_narrow (smp_narrow),
      .rd_hit     (bus_rd && bus_addr == ADDR_W'(g)),
      .fmt        (fmt),
      .view       (axis_view[g])
    );
  end

  accel_cfg_bank #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .wr          (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .rd_byte     (cfg_byte),
    .mode_active (cfg_mode),
    .range_sel   (cfg_range)
  );

  accel_rd_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .AXES   (AXES)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .rd        (bus_rd),
    .addr      (bus_addr),
    .axis_view (axis_view),
    .cfg_byte  (cfg_byte),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/accel_sample_regs_chk.sv
module accel_sample_regs_chk
  import accel_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NARROW_W = 6,
  parameter int unsigned AXES     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [AXES-1:0]   smp_wr,
  input logic              cfg_mode,
  input logic [1:0]        cfg_range
);

  logic axis_rd;
  logic same_axis_upd;
  logic unmapped;

  always_comb begin
    axis_rd       = 1'b0;
    same_axis_upd = 1'b0;
    for (int i = 0; i < AXES; i++) begin
      if (bus_addr == ADDR_W'(i)) begin
        axis_rd       = bus_rd;
        same_axis_upd = smp_wr[i];
      end
    end
    unmapped = !(bus_addr < ADDR_W'(AXES)) &&
               ((bus_addr < ADDR_W'(CFG_FIRST)) || (bus_addr > ADDR_W'(CFG_LAST)) ||
                (bus_addr == ADDR_W'(CFG_HOLE_A)) || (bus_addr == ADDR_W'(CFG_HOLE_B)));
  end

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_narrow_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (axis_rd && cfg_range == 2'b00) |=> !bus_rdata[DATA_W-1]);

  assert_alert_on_collide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (axis_rd && same_axis_upd && cfg_range == 2'b00) |=> bus_rdata[NARROW_W]);

  assert_alert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (axis_rd && !same_axis_upd && cfg_range == 2'b00) |=> !bus_rdata[NARROW_W]);

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> (bus_rdata == '0));

  assert_active_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && bus_wr && bus_addr != ADDR_W'(MODE_ADDR)) |=> ($stable(cfg_range) && cfg_mode));

endmodule

bind accel_sample_regs accel_sample_regs_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NARROW_W (NARROW_W),
  .AXES     (AXES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .smp_wr    (smp_wr),
  .cfg_mode  (cfg_mode),
  .cfg_range (cfg_range)
);

// File: tb/accel_sample_regs_tb.sv
module accel_sample_regs_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] smp_wr = '0;
  logic [7:0] smp_data = '0;
  logic       smp_narrow = 1'b0;
  logic       cfg_mode;
  logic [1:0] cfg_range;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  accel_sample_regs u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .smp_wr     (smp_wr),
    .smp_data   (smp_data),
    .smp_narrow (smp_narrow),
    .cfg_mode   (cfg_mode),
    .cfg_range  (cfg_range)
  );

  // Monitor: one expected byte per read, compared one cycle later
  always @(posedge clk) rd_d <= bus_rd;

  always @(negedge clk) begin
    if (rd_d) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: actual %02h expected none", bus_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic idle();
    bus_rd = 1'b0; bus_wr = 1'b0; smp_wr = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic upd(input int ax, input logic [7:0] d, input logic nar);
    @(negedge clk);
    smp_wr = '0; smp_wr[ax] = 1'b1; smp_data = d; smp_narrow = nar;
    @(negedge clk);
    idle();
  endtask

  // Read of address a in the same cycle as an update of axis ax
  task automatic rd_upd(input logic [7:0] a, input int ax, input logic [7:0] d,
                        input logic [7:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    smp_wr = '0; smp_wr[ax] = 1'b1; smp_data = d; smp_narrow = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    idle();
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", t, act, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h00, 8'h00, "R1 X reset");
    rd(8'h01, 8'h00, "R1 Y reset");
    rd(8'h02, 8'h00, "R1 Z reset");
    rd(8'h07, 8'h00, "R1 mode reset");
    rd(8'h13, 8'h00, "R1 range reset");

    // R2 narrow formatting
    upd(0, 8'h15, 1'b0);
    rd(8'h00, 8'h15, "R2 X narrow");
    upd(1, 8'hE0, 1'b0);
    rd(8'h01, 8'h20, "R2 Y narrow -32 bit7 zero");

    // R4 / R5 collision then clean read
    rd_upd(8'h00, 0, 8'h0A, 8'h55, "R4 X collide alert old data");
    rd(8'h00, 8'h0A, "R5 X clean reread");

    // R6 other axis update
    rd_upd(8'h00, 1, 8'h07, 8'h0A, "R6 no alert from Y update");
    rd(8'h01, 8'h07, "R6 Y new value");

    // R11 standby writes
    wr(8'h09, 8'hA5);
    rd(8'h09, 8'hA5, "R11 cfg 0x09 readback");
    wr(8'h13, 8'hC3);
    rd(8'h13, 8'hC3, "R11 cfg 0x13 readback");
    @(negedge clk);
    chk({6'd0, cfg_range}, 8'h03, "R13 cfg_range");

    // R3 wide mode
    upd(2, 8'h9C, 1'b0);
    rd(8'h02, 8'h9C, "R3 Z wide");
    rd_upd(8'h00, 0, 8'h7F, 8'h0A, "R3 wide collide no alert");
    rd(8'h00, 8'h7F, "R3 X wide new");

    // R7 sign extension of six-bit samples
    upd(2, 8'h25, 1'b1);
    rd(8'h02, 8'hE5, "R7 Z negative extend");
    upd(2, 8'hDA, 1'b1);
    rd(8'h02, 8'h1A, "R7 Z positive input top ignored");

    // R9 axis bytes read-only
    wr(8'h00, 8'h33);
    rd(8'h00, 8'h7F, "R9 X write ignored");

    // R12 reserved and unmapped
    wr(8'h0A, 8'hFF);
    rd(8'h0A, 8'h00, "R12 hole 0x0A");
    wr(8'h30, 8'hFF);
    rd(8'h30, 8'h00, "R12 unmapped 0x30");
    rd(8'h04, 8'h00, "R12 unmapped 0x04");

    // R10 active gating
    wr(8'h07, 8'h01);
    @(negedge clk);
    chk({7'd0, cfg_mode}, 8'h01, "R13 cfg_mode active");
    wr(8'h09, 8'h11);
    rd(8'h09, 8'hA5, "R10 cfg write ignored while active");
    wr(8'h13, 8'h00);
    rd(8'h13, 8'hC3, "R10 range write ignored while active");
    wr(8'h07, 8'h00);
    rd(8'h07, 8'h00, "R10 mode write accepted while active");
    wr(8'h13, 8'h00);
    rd(8'h00, 8'h3F, "R2 X narrow after return, bit7 zero");

    // R8 hold across idle cycles and updates
    upd(0, 8'h01, 1'b0);
    repeat (3) @(negedge clk);
    chk(bus_rdata, 8'h3F, "R8 rdata held");

    repeat (3) @(negedge clk);
    done = 1'b1;
    if (exp_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule